// File: doc/BRIEF.md
# DDR read strobe burst sequencer

This block is the memory-side read output path of a double-data-rate SDRAM model. It runs on a clock at twice the base clock rate, so every register step is one half-cycle tick. A READ request is taken only on ticks that begin the high half of the base clock. A taken request latches a whole burst of words from the storage array. The block then sends the words out one per half-cycle on the data pins, starting after a fractional CAS latency. The strobe is driven alongside the data, and each pin group has its own output enable so that high impedance can be represented.

When the strobe is idle, it leaves high impedance and is held low for one full base cycle before the first word. This is the preamble. After the last word it is held low for one more half-cycle and then released. This is the postamble. Reads spaced two base cycles apart run with no gap, and the strobe keeps toggling between them. Reads spaced three base cycles apart have the postamble of the first burst fused with the preamble of the second, so the strobe stays driven low. A request that comes too soon after the last accepted one is dropped and sets a sticky error flag.

Top module: `ddrrd_strobe_seq`

## Requirements
- R1: While reset is held, and right after it, dq_oe_o, dqs_oe_o, dqs_o, rd_err_o and ck_phase_o are all 0, and no burst is pending. Reset also clears the error flag.
- R2: ck_phase_o toggles on every clk2x_i edge and reads 1 for the half-cycle after a sampling edge. rd_req_i is sampled only on edges where ck_phase_o was 0. A request held only across an edge where ck_phase_o was 1 causes no output activity and no error.
- R3: Take a request accepted at edge E. Word i of rd_burst_i (bits [16*i+15:16*i], i = 0..3) appears on dq_o for the half-cycle after edge E+5+i. This makes the CAS latency 2.5 base cycles.
- R4: dq_oe_o is 1 only during the four data half-cycles of each burst. Whenever dq_oe_o is 0, dq_o reads 0.
- R5: When no burst is active, dqs_oe_o rises two half-cycles before the first word, which are the half-cycles after E+3 and E+4. During those two half-cycles dqs_o is 0.
- R6: During data half-cycles dqs_o is 1 for words 0 and 2 and 0 for words 1 and 3. Outside data half-cycles dqs_o is 0.
- R7: After the last word of a burst with no read following, dqs_o stays driven low for one half-cycle (after E+9). dqs_oe_o then falls to 0 (after E+10).
- R8: A request accepted exactly 4 ticks (two base cycles) after the previous one gives eight back-to-back data half-cycles. Between the two bursts there is no preamble and no postamble, and dqs_o keeps alternating.
- R9: A request accepted 6 ticks after the previous one holds dqs_oe_o at 1 through the gap. The overlapping postamble and preamble keep dqs_o driven low for two half-cycles.
- R10: A request sampled fewer than 4 ticks after the last accepted request is ignored and sets rd_err_o, which stays 1 until reset. An ignored request does not restart the spacing count.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk2x_i | input | 1 | Double-rate clock, one edge per half base cycle |
| rst_n_i | input | 1 | Active-low synchronous reset |
| rd_req_i | input | 1 | READ request, sampled when ck_phase_o is 0 |
| rd_burst_i | input | 64 | Burst words from the array, word 0 in the low bits |
| ck_phase_o | output | 1 | Base clock level reconstructed from the tick phase |
| dq_o | output | 16 | Data pin value |
| dq_oe_o | output | 1 | Data output enable (0 = high impedance) |
| dqs_o | output | 1 | Strobe pin value |
| dqs_oe_o | output | 1 | Strobe output enable (0 = high impedance) |
| rd_err_o | output | 1 | Sticky flag for a request that came too soon |

## Verification
The toggle, preamble and postamble properties assume that two bursts never share a data half-cycle. The design itself guarantees this by dropping early requests, so the properties rely only on the reset-aligned phase and not on well-behaved stimulus. The stimulus changes rd_req_i only between edges. It picks the sampling or non-sampling phase on purpose and sets the spacing between requests on purpose: four ticks, six ticks, two ticks for a rejected request, and a retry at four ticks from the last accepted request. This covers the seamless, fused and rejected cases and nothing outside the spacing rule.

// File: rtl/ddrrd_pkg.sv
package ddrrd_pkg;
   typedef struct packed {
      logic dq_oe;
      logic dqs_oe;
      logic dqs;
   } pin_ctl_t;
endpackage

// File: rtl/ddrrd_phase_gate.sv
module ddrrd_phase_gate #(
   parameter int MIN_GAP = 4
) (
   input  logic clk2x_i,
   input  logic rst_n_i,
   input  logic rd_req_i,
   output logic ph_o,
   output logic accept_o,
   output logic err_o
);
   localparam int GW = $clog2(MIN_GAP + 1);

   logic          ph_q;
   logic [GW-1:0] gap_q;
   logic          err_q;
   logic          spaced;

   assign spaced   = (gap_q == GW'(MIN_GAP));
   assign accept_o = rd_req_i && !ph_q && spaced;
   assign ph_o     = ph_q;
   assign err_o    = err_q;

   always_ff @(posedge clk2x_i) begin
      if (!rst_n_i) begin
         ph_q  <= 1'b0;
         gap_q <= GW'(MIN_GAP);
         err_q <= 1'b0;
      end else begin
         ph_q <= ~ph_q;
         if (accept_o)
            gap_q <= GW'(1);
         else if (!spaced)
            gap_q <= gap_q + GW'(1);
         if (rd_req_i && !ph_q && !spaced)
            err_q <= 1'b1;
      end
   end
endmodule

// File: rtl/ddrrd_burst_slot.sv
module ddrrd_burst_slot
   import ddrrd_pkg::*;
#(
   parameter int W       = 16,
   parameter int BL      = 4,
   parameter int CL_HALF = 5
) (
   input  logic            clk2x_i,
   input  logic            rst_n_i,
   input  logic            load_i,
   input  logic [BL*W-1:0] burst_i,
   output pin_ctl_t        ctl_o,
   output logic [W-1:0]    dq_o
);
   localparam int LAST = CL_HALF + BL;
   localparam int AW   = $clog2(LAST + 1);
   localparam int IW   = (BL > 1) ? $clog2(BL) : 1;

   logic            busy_q;
   logic [AW-1:0]   age_q;
   logic [BL*W-1:0] words_q;
   logic [AW-1:0]   offs;
   logic [IW-1:0]   idx;
   logic            in_pre, in_dat, in_post;

   always_ff @(posedge clk2x_i) begin
      if (!rst_n_i) begin
         busy_q  <= 1'b0;
         age_q   <= '0;
         words_q <= '0;
      end else if (load_i) begin
         busy_q  <= 1'b1;
         age_q   <= '0;
         words_q <= burst_i;
      end else if (busy_q) begin
         if (age_q == AW'(LAST))
            busy_q <= 1'b0;
         else
            age_q <= age_q + AW'(1);
      end
   end

   always_comb begin
      offs    = age_q - AW'(CL_HALF);
      idx     = offs[IW-1:0];
      in_pre  = busy_q && (age_q >= AW'(CL_HALF - 2)) && (age_q < AW'(CL_HALF));
      in_dat  = busy_q && (age_q >= AW'(CL_HALF)) && (age_q < AW'(LAST));
      in_post = busy_q && (age_q == AW'(LAST));
      ctl_o.dq_oe  = in_dat;
      ctl_o.dqs_oe = in_pre | in_dat | in_post;
      ctl_o.dqs    = in_dat & ~idx[0];
      dq_o = in_dat ? words_q[idx*W +: W] : '0;
   end
endmodule

// File: rtl/ddrrd_pin_merge.sv
module ddrrd_pin_merge
   import ddrrd_pkg::*;
#(
   parameter int W = 16,
   parameter int N = 3
) (
   input  pin_ctl_t [N-1:0]        ctl_i,
   input  logic [N-1:0][W-1:0]     dq_i,
   output logic [W-1:0]            dq_o,
   output logic                    dq_oe_o,
   output logic                    dqs_o,
   output logic                    dqs_oe_o
);
   always_comb begin
      dq_o     = '0;
      dq_oe_o  = 1'b0;
      dqs_o    = 1'b0;
      dqs_oe_o = 1'b0;
      for (int k = 0; k < N; k++) begin
         dq_o     = dq_o | dq_i[k];
         dq_oe_o  = dq_oe_o | ctl_i[k].dq_oe;
         dqs_o    = dqs_o | ctl_i[k].dqs;
         dqs_oe_o = dqs_oe_o | ctl_i[k].dqs_oe;
      end
   end
endmodule

// File: rtl/ddrrd_strobe_seq.sv
module ddrrd_strobe_seq
   import ddrrd_pkg::*;
#(
   parameter int W       = 16,
   parameter int BL      = 4,
   parameter int CL_HALF = 5,
   parameter int MIN_GAP = 4
) (
   input  logic            clk2x_i,
   input  logic            rst_n_i,
   input  logic            rd_req_i,
   input  logic [BL*W-1:0] rd_burst_i,
   output logic            ck_phase_o,
   output logic [W-1:0]    dq_o,
   output logic            dq_oe_o,
   output logic            dqs_o,
   output logic            dqs_oe_o,
   output logic            rd_err_o
);
   localparam int LIFE = CL_HALF + BL + 1;
   localparam int NTRK = (LIFE + MIN_GAP - 1) / MIN_GAP;
   localparam int PW   = (NTRK > 1) ? $clog2(NTRK) : 1;

   if (CL_HALF < 3) begin : g_bad_cl
      $error("CL_HALF must leave room for a two-tick preamble");
   end
   if (BL < 2 || (BL % 2) != 0) begin : g_bad_bl
      $error("BL must be even and at least 2");
   end
   if (MIN_GAP < BL || (MIN_GAP % 2) != 0) begin : g_bad_gap
      $error("MIN_GAP must be even and no shorter than a burst");
   end

   logic                accept;
   logic                ph;
   logic [PW-1:0]       ptr_q;
   pin_ctl_t [NTRK-1:0] ctl;
   logic [NTRK-1:0][W-1:0] dq_part;

   ddrrd_phase_gate #(.MIN_GAP(MIN_GAP)) u_gate (
      .clk2x_i  (clk2x_i),
      .rst_n_i  (rst_n_i),
      .rd_req_i (rd_req_i),
      .ph_o     (ph),
      .accept_o (accept),
      .err_o    (rd_err_o)
   );

   if (NTRK == 1) begin : g_single
      assign ptr_q = '0;
   end else begin : g_rr
      always_ff @(posedge clk2x_i) begin
         if (!rst_n_i)
            ptr_q <= '0;
         else if (accept)
            ptr_q <= (ptr_q == PW'(NTRK - 1)) ? '0 : ptr_q + PW'(1);
      end
   end

   for (genvar t = 0; t < NTRK; t++) begin : g_trk
      ddrrd_burst_slot #(.W(W), .BL(BL), .CL_HALF(CL_HALF)) u_slot (
         .clk2x_i (clk2x_i),
         .rst_n_i (rst_n_i),
         .load_i  (accept && (ptr_q == PW'(t))),
         .burst_i (rd_burst_i),
         .ctl_o   (ctl[t]),
         .dq_o    (dq_part[t])
      );
   end

   ddrrd_pin_merge #(.W(W), .N(NTRK)) u_merge (
      .ctl_i    (ctl),
      .dq_i     (dq_part),
      .dq_o     (dq_o),
      .dq_oe_o  (dq_oe_o),
      .dqs_o    (dqs_o),
      .dqs_oe_o (dqs_oe_o)
   );

   assign ck_phase_o = ph;
endmodule

// File: rtl/ddrrd_strobe_seq_chk.sv
module ddrrd_strobe_seq_chk #(
   parameter int W = 16
) (
   input logic         clk2x_i,
   input logic         rst_n_i,
   input logic         ck_phase_o,
   input logic [W-1:0] dq_o,
   input logic         dq_oe_o,
   input logic         dqs_o,
   input logic         dqs_oe_o,
   input logic         rd_err_o
);
   a_r2_phase_toggles: assert property (@(posedge clk2x_i) disable iff (!rst_n_i)
      1'b1 |=> (ck_phase_o != $past(ck_phase_o)));
   a_r4_dq_under_strobe: assert property (@(posedge clk2x_i) disable iff (!rst_n_i)
      dq_oe_o |-> dqs_oe_o);
   a_r4_dq_quiet: assert property (@(posedge clk2x_i) disable iff (!rst_n_i)
      !dq_oe_o |-> (dq_o == '0));
   a_r5_preamble_low: assert property (@(posedge clk2x_i) disable iff (!rst_n_i)
      $rose(dqs_oe_o) |-> (!dqs_o && !dq_oe_o));
   a_r6_high_only_data: assert property (@(posedge clk2x_i) disable iff (!rst_n_i)
      dqs_o |-> dq_oe_o);
   a_r6_r8_toggle: assert property (@(posedge clk2x_i) disable iff (!rst_n_i)
      (dq_oe_o && $past(dq_oe_o)) |-> (dqs_o != $past(dqs_o)));
   a_r7_postamble_low: assert property (@(posedge clk2x_i) disable iff (!rst_n_i)
      $fell(dq_oe_o) |-> (dqs_oe_o && !dqs_o));
   a_r7_release_after_low: assert property (@(posedge clk2x_i) disable iff (!rst_n_i)
      $fell(dqs_oe_o) |-> (!$past(dqs_o) && !$past(dq_oe_o)));
   a_r10_err_sticky: assert property (@(posedge clk2x_i) disable iff (!rst_n_i)
      rd_err_o |=> rd_err_o);
endmodule

bind ddrrd_strobe_seq ddrrd_strobe_seq_chk #(.W(W)) u_chk (
   .clk2x_i    (clk2x_i),
   .rst_n_i    (rst_n_i),
   .ck_phase_o (ck_phase_o),
   .dq_o       (dq_o),
   .dq_oe_o    (dq_oe_o),
   .dqs_o      (dqs_o),
   .dqs_oe_o   (dqs_oe_o),
   .rd_err_o   (rd_err_o)
);

// File: tb/ddrrd_strobe_seq_tb_top.sv
module ddrrd_strobe_seq_tb_top;
   localparam int W  = 16;
   localparam int BL = 4;
   localparam int ES = 4096;

   logic          clk2x = 1'b0;
   logic          rst_n = 1'b0;
   logic          rd_req = 1'b0;
   logic [BL*W-1:0] rd_burst = '0;
   logic          ck_phase, dq_oe, dqs, dqs_oe, rd_err;
   logic [W-1:0]  dq;

   ddrrd_strobe_seq dut_i (
      .clk2x_i(clk2x), .rst_n_i(rst_n), .rd_req_i(rd_req), .rd_burst_i(rd_burst),
      .ck_phase_o(ck_phase), .dq_o(dq), .dq_oe_o(dq_oe), .dqs_o(dqs),
      .dqs_oe_o(dqs_oe), .rd_err_o(rd_err)
   );

   always #2 clk2x = ~clk2x;

   int edges = 0;
   always @(posedge clk2x) begin
      if (!rst_n) edges <= 0;
      else        edges <= edges + 1;
   end

   bit e_dqoe [ES];
   bit e_dqsoe[ES];
   bit e_dqs  [ES];
   logic [W-1:0] wq[$];
   int  n_chk = 0, n_err = 0;
   bit  mon_on = 0, done = 0;
   int  last_acc = -100;

   task automatic chk(input bit ok, input string req, input string what,
                      input longint act, input longint exp);
      n_chk++;
      if (!ok) begin
         n_err++;
         $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
      end
   endtask

   task automatic summary();
      if (!done) begin
         done = 1;
         $display("Result: errors=%0d of %0d checks", n_err, n_chk);
         $finish;
      end
   endtask

   // monitor: compares each half-cycle to the expected timeline, pops data words
   always @(negedge clk2x) begin
      if (mon_on && rst_n && edges > 0 && edges <= ES) begin
         int l;
         l = edges - 1;
         chk(ck_phase === ((l % 2) == 0), "R2", "ck_phase", ck_phase, (l % 2) == 0);
         chk(dq_oe === e_dqoe[l], "R4/R8", "dq_oe", dq_oe, e_dqoe[l]);
         chk(dqs_oe === e_dqsoe[l], "R5/R7/R9", "dqs_oe", dqs_oe, e_dqsoe[l]);
         if (e_dqsoe[l])
            chk(dqs === e_dqs[l], "R6/R8/R9", "dqs", dqs, e_dqs[l]);
         if (e_dqoe[l] && dq_oe) begin
            if (wq.size() == 0)
               chk(1'b0, "R3", "dq queue empty", dq, 0);
            else begin
               logic [W-1:0] w;
               w = wq.pop_front();
               chk(dq === w, "R3", "dq word", dq, w);
            end
         end
      end
   end

   task automatic skip(input int n);
      repeat (n) @(negedge clk2x);
   endtask

   // driver: called at a negedge; odd selects the non-sampling phase
   task automatic rd(input logic [BL*W-1:0] w, input bit odd);
      int e0;
      while (((edges % 2) == 1) != odd) @(negedge clk2x);
      e0 = edges;
      rd_req = 1'b1;
      rd_burst = w;
      if (!odd && (e0 - last_acc) >= 4) begin
         last_acc = e0;
         for (int a = 3; a <= 9; a++) begin
            if (e0 + a < ES) begin
               e_dqsoe[e0 + a] = 1'b1;
               if (a >= 5 && a <= 8) begin
                  e_dqoe[e0 + a] = 1'b1;
                  e_dqs[e0 + a]  = ((a - 5) % 2) == 0;
               end
            end
         end
         for (int i = 0; i < BL; i++) wq.push_back(w[i*W +: W]);
      end
      @(negedge clk2x);
      rd_req = 1'b0;
   endtask

   task automatic do_reset();
      mon_on = 0;
      rst_n  = 1'b0;
      rd_req = 1'b0;
      for (int i = 0; i < ES; i++) begin
         e_dqoe[i] = 0; e_dqsoe[i] = 0; e_dqs[i] = 0;
      end
      wq.delete();
      last_acc = -100;
      skip(3);
      chk(dq_oe === 1'b0 && dqs_oe === 1'b0, "R1", "pins released", {dq_oe, dqs_oe}, 0);
      chk(rd_err === 1'b0 && dqs === 1'b0, "R1", "err/dqs clear", {rd_err, dqs}, 0);
      chk(ck_phase === 1'b0, "R1", "phase", ck_phase, 0);
      rst_n  = 1'b1;
      mon_on = 1;
   endtask

   initial begin
      #800000;
      n_chk++; n_err++;
      $display("FAIL watchdog: actual=running expected=finished");
      summary();
   end

   initial begin
      @(negedge clk2x);
      do_reset();
      skip(3);
      // single burst: latency, order, preamble, postamble
      rd(64'h4444_3333_2222_1111, 0);
      skip(14);
      // request only on the non-sampling phase
      rd(64'hdead_beef_cafe_f00d, 1);
      skip(14);
      chk(rd_err === 1'b0, "R2", "no error from odd-phase request", rd_err, 0);
      // gapless chain at 4 ticks
      rd(64'ha003_a002_a001_a000, 0); skip(2);
      rd(64'hb003_b002_b001_b000, 0); skip(2);
      rd(64'hc003_c002_c001_c000, 0);
      skip(16);
      // 6-tick spacing: fused postamble and preamble
      rd(64'hd003_d002_d001_d000, 0); skip(4);
      rd(64'he003_e002_e001_e000, 0);
      skip(16);
      chk(rd_err === 1'b0, "R10", "no error before violation", rd_err, 0);
      // too-soon request, then retry counted from the accepted one
      rd(64'hf003_f002_f001_f000, 0);
      rd(64'h9999_9999_9999_9999, 0);
      skip(1);
      rd(64'h1703_1702_1701_1700, 0);
      skip(16);
      chk(rd_err === 1'b1, "R10", "sticky error set", rd_err, 1);
      chk(wq.size() == 0, "R10", "all expected words seen", wq.size(), 0);
      skip(10);
      chk(rd_err === 1'b1, "R10", "error still held", rd_err, 1);
      do_reset();
      skip(2);
      chk(rd_err === 1'b0, "R1", "error cleared by reset", rd_err, 0);
      summary();
   end
endmodule